// File: doc/BRIEF.md
# Instruction TLB Least-Recently-Used Tracker

This block keeps the age order of the four ways of a small instruction TLB. The order is held as six pairwise "which way was used later" flags in the upper bits of a 32-bit MMU control register. The rest of that register is plain storage that the block never changes. Each bit records, for one pair of ways, which of the two was touched more recently. Any full order of the four ways is therefore one 6-bit pattern.

When the instruction TLB reports a hit on a way, the block clears and sets fixed flag bits so that way becomes the newest. When the TLB misses and must load a way, the fill strobe asks for a victim. The block decodes the flags into the oldest way, registers that way number, and marks the way as just used in the same cycle. The copy of the translation into that way is done elsewhere. Software can read and write the whole control register, and a write overrides any hardware update in the same cycle.

Top module: `itlb_lru_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the control register clears to 0 and `victim` clears to 0.
- R2: When `csr_we` is high, the control register takes all 32 bits of `csr_wdata`, and `csr_rdata` shows them after that edge.
- R3: A hit with `hit_vld` high on way n (`hit_idx`) changes the flags as follows when there is no write and no fill. For n=0, bits 31, 30 and 29 clear. For n=1, bits 28 and 27 clear and bit 31 sets. For n=2, bits 30 and 28 set and bit 26 clears. For n=3, bits 29, 27 and 26 set. All other flag bits keep their value.
- R4: A hit or a fill never changes bits 25:0 of the control register.
- R5: The victim is decoded from bits 31:26 in this priority order. It is way 0 if bits 31, 30 and 29 are all 1. Otherwise it is way 1 if bit 31 is 0 and bits 28 and 27 are 1. Otherwise it is way 2 if bits 30 and 28 are 0 and bit 26 is 1. Otherwise it is way 3 if bits 29, 27 and 26 are 0.
- R6: A flag pattern that matches none of the four rules of R5 yields victim 0.
- R7: On `fill_req`, `victim` takes the way decoded from the flags before that edge. Without a write, the flags are updated as for a hit on that way (R3). `victim` holds its value until the next fill.
- R8: A `csr_we` in the same cycle as a hit or a fill wins over the flag update. A fill in that cycle still latches its victim from the flags before the write.
- R9: A hit presented in the same cycle as `fill_req` is ignored.
- R10: With no write, hit or fill, the control register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_vld | input | 1 | Instruction TLB hit this cycle |
| hit_idx | input | 2 | Way that hit |
| fill_req | input | 1 | Request for a victim way for a fill |
| victim | output | 2 | Way chosen by the last fill (registered) |
| csr_we | input | 1 | Write strobe for the control register |
| csr_wdata | input | 32 | Write data for the control register |
| csr_rdata | output | 32 | Current control register value |

## Verification
Every one of the 64 flag patterns is loaded through the register port and then filled. This separates each of the four priority rules from its neighbours and from the invalid-pattern default, and it also checks the flags written back after each fill. Hits on each way start from patterns with the low 26 bits all ones and all zeros, so that a mask reaching outside the flag field shows up. Ordered hit sequences (0-1-2-3 and 3-2-1-0) check that the oldest way is found after a real history. Same-cycle collisions of write, hit and fill show which update has priority.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int CTRL_W   = 32;
  localparam int TOP_LSB  = 24;
  localparam int TOP_W    = CTRL_W - TOP_LSB;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = $clog2(NUM_WAYS);

  // Update masks applied to the top byte of the control register.
  typedef struct packed {
    logic [TOP_W-1:0] keep;
    logic [TOP_W-1:0] set;
  } upd_mask_t;

  // Decode rule: the top byte under care must equal val.
  typedef struct packed {
    logic [TOP_W-1:0] care;
    logic [TOP_W-1:0] val;
  } vic_rule_t;

  function automatic upd_mask_t way_mask(input int way);
    upd_mask_t m;
    case (way)
      0:       begin m.keep = 8'h1F; m.set = 8'h00; end
      1:       begin m.keep = 8'hE7; m.set = 8'h80; end
      2:       begin m.keep = 8'hFB; m.set = 8'h50; end
      default: begin m.keep = 8'hFF; m.set = 8'h2C; end
    endcase
    return m;
  endfunction

  function automatic vic_rule_t way_rule(input int way);
    vic_rule_t r;
    case (way)
      0:       begin r.care = 8'hE0; r.val = 8'hE0; end
      1:       begin r.care = 8'h98; r.val = 8'h18; end
      2:       begin r.care = 8'h54; r.val = 8'h04; end
      default: begin r.care = 8'h2C; r.val = 8'h00; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/itlb_lru_update.sv
module itlb_lru_update
  import itlb_lru_pkg::*;
#(
  parameter int W     = CTRL_W,
  parameter int SHIFT = TOP_LSB,
  parameter int WAYS  = NUM_WAYS,
  localparam int IW   = $clog2(WAYS)
) (
  input  logic [W-1:0]  cur,
  input  logic [IW-1:0] way,
  output logic [W-1:0]  nxt
);
  localparam int HW = W - SHIFT;

  logic [HW-1:0] cand [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    localparam upd_mask_t M = way_mask(g);
    assign cand[g] = (cur[W-1:SHIFT] & M.keep) | M.set;
  end

  assign nxt = {cand[way], cur[SHIFT-1:0]};
endmodule

// File: rtl/itlb_lru_decode.sv
module itlb_lru_decode
  import itlb_lru_pkg::*;
#(
  parameter int HW   = TOP_W,
  parameter int WAYS = NUM_WAYS,
  localparam int IW  = $clog2(WAYS)
) (
  input  logic [HW-1:0] top,
  output logic [IW-1:0] way
);
  logic [WAYS-1:0] hit;

  for (genvar g = 0; g < WAYS; g++) begin : g_rule
    localparam vic_rule_t R = way_rule(g);
    assign hit[g] = (top & R.care) == R.val;
  end

  // Lowest matching way wins; no match falls back to way 0.
  always_comb begin
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit[i]) way = IW'(i);
    end
  end
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
  import itlb_lru_pkg::*;
#(
  parameter int W     = CTRL_W,
  parameter int SHIFT = TOP_LSB,
  parameter int WAYS  = NUM_WAYS,
  localparam int IW   = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_vld,
  input  logic [IW-1:0] hit_idx,
  input  logic          fill_req,
  output logic [IW-1:0] victim,
  input  logic          csr_we,
  input  logic [W-1:0]  csr_wdata,
  output logic [W-1:0]  csr_rdata
);
  logic [W-1:0]  ctrl_q;
  logic [IW-1:0] vic_q;
  logic [IW-1:0] dec_way;
  logic [IW-1:0] upd_way;
  logic [W-1:0]  upd_val;

  itlb_lru_decode #(.HW(W - SHIFT), .WAYS(WAYS)) u_dec (
    .top (ctrl_q[W-1:SHIFT]),
    .way (dec_way)
  );

  // A fill marks its own victim as used; otherwise the hit way is used.
  assign upd_way = fill_req ? dec_way : hit_idx;

  itlb_lru_update #(.W(W), .SHIFT(SHIFT), .WAYS(WAYS)) u_upd (
    .cur (ctrl_q),
    .way (upd_way),
    .nxt (upd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      vic_q  <= '0;
    end else begin
      if (fill_req) vic_q <= dec_way;
      if (csr_we)                   ctrl_q <= csr_wdata;
      else if (fill_req || hit_vld) ctrl_q <= upd_val;
    end
  end

  assign csr_rdata = ctrl_q;
  assign victim    = vic_q;

  p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
    csr_we |=> csr_rdata == $past(csr_wdata));

  p_low_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !csr_we |=> csr_rdata[25:0] == $past(csr_rdata[25:0]));

  p_hit0_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && hit_idx == 2'd0 && !fill_req && !csr_we) |=> csr_rdata[31:29] == 3'b000);

  p_hit3_set_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && hit_idx == 2'd3 && !fill_req && !csr_we)
      |=> (csr_rdata[29] && csr_rdata[27] && csr_rdata[26]));

  p_fill_mru_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !csr_we) |=> (victim != 2'd0 || csr_rdata[31:29] == 3'b000));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!csr_we && !hit_vld && !fill_req) |=> $stable(csr_rdata));

  p_victim_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> $stable(victim));
endmodule

// File: tb/sim_itlb_lru_tracker.sv
module sim_itlb_lru_tracker;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit_vld = 1'b0;
  logic [1:0]  hit_idx = '0;
  logic        fill_req = 1'b0;
  logic [1:0]  victim;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  itlb_lru_tracker u0 (
    .clk, .rst, .hit_vld, .hit_idx, .fill_req, .victim,
    .csr_we, .csr_wdata, .csr_rdata
  );

  // Bench model: flags h[5:0] stand for register bits 31:26.
  function automatic logic [5:0] m_use(input logic [5:0] h, input logic [1:0] w);
    case (w)
      2'd0:    return h & ~6'b111000;
      2'd1:    return (h & ~6'b000110) | 6'b100000;
      2'd2:    return (h & ~6'b000001) | 6'b010100;
      default: return h | 6'b001011;
    endcase
  endfunction

  function automatic logic [1:0] m_old(input logic [5:0] h);
    if (h[5] && h[4] && h[3])        return 2'd0;
    if (!h[5] && h[2] && h[1])       return 2'd1;
    if (!h[4] && !h[2] && h[0])      return 2'd2;
    if (!h[3] && !h[1] && !h[0])     return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive inputs for one edge, then clear them just after it.
  task automatic step(input logic we, input logic [31:0] wd, input logic hv,
                      input logic [1:0] hi, input logic fr);
    @(negedge clk);
    csr_we = we; csr_wdata = wd; hit_vld = hv; hit_idx = hi; fill_req = fr;
    @(posedge clk);
    #1;
    csr_we = 1'b0; hit_vld = 1'b0; fill_req = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    step(1'b1, d, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", csr_rdata, 32'h0);
    chk("R1 victim", {30'd0, victim}, 32'h0);
  endtask

  task automatic t_write;
    wr(32'hA5A5_1234);
    chk("R2 readback", csr_rdata, 32'hA5A5_1234);
    wr(32'h0000_0000);
    chk("R2 readback zero", csr_rdata, 32'h0);
  endtask

  task automatic t_hits;
    logic [31:0] base [2];
    base[0] = 32'h03FF_FFFF;
    base[1] = 32'hFC00_0000;
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 4; w++) begin
        wr(base[b]);
        step(1'b0, 32'h0, 1'b1, 2'(w), 1'b0);
        chk("R3 hit flags", {26'd0, csr_rdata[31:26]},
            {26'd0, m_use(base[b][31:26], 2'(w))});
        chk("R4 low bits", {6'd0, csr_rdata[25:0]}, {6'd0, base[b][25:0]});
      end
    end
  endtask

  task automatic t_all_patterns;
    for (int p = 0; p < 64; p++) begin
      logic [31:0] v;
      v = {6'(p), 26'h15A_5A5A};
      wr(v);
      step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1);
      chk("R5 R6 victim", {30'd0, victim}, {30'd0, m_old(6'(p))});
      chk("R7 flags after fill", csr_rdata, {m_use(6'(p), m_old(6'(p))), v[25:0]});
    end
    wr({6'b010101, 26'h0});
    step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1);
    chk("R6 invalid defaults to 0", {30'd0, victim}, 32'd0);
  endtask

  task automatic t_sequences;
    wr(32'h0);
    for (int w = 0; w < 4; w++) step(1'b0, 32'h0, 1'b1, 2'(w), 1'b0);
    step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1);
    chk("R5 oldest after 0123", {30'd0, victim}, 32'd0);
    for (int w = 3; w >= 0; w--) step(1'b0, 32'h0, 1'b1, 2'(w), 1'b0);
    step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1);
    chk("R5 oldest after 3210", {30'd0, victim}, 32'd3);
    repeat (3) @(posedge clk);
    #1;
    chk("R7 victim held", {30'd0, victim}, 32'd3);
  endtask

  task automatic t_collisions;
    wr(32'h0000_00FF);
    step(1'b0, 32'h0, 1'b1, 2'd1, 1'b1);
    chk("R9 victim on fill", {30'd0, victim}, 32'd3);
    chk("R9 hit ignored", csr_rdata, {m_use(6'b0, 2'd3), 26'h0FF});
    wr(32'h1234_5678);
    step(1'b1, 32'hFFFF_0000, 1'b1, 2'd0, 1'b0);
    chk("R8 write beats hit", csr_rdata, 32'hFFFF_0000);
    wr({6'b111000, 26'h0});
    step(1'b1, 32'h0000_0001, 1'b0, 2'd0, 1'b1);
    chk("R8 write beats fill", csr_rdata, 32'h0000_0001);
    chk("R8 victim from old flags", {30'd0, victim}, 32'd0);
  endtask

  task automatic t_idle;
    wr(32'hDEAD_BEEF);
    repeat (4) @(posedge clk);
    #1;
    chk("R10 hold", csr_rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_rst_again;
    wr(32'hFFFF_FFFF);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    chk("R1 reset clears ctrl", csr_rdata, 32'h0);
    chk("R1 reset clears victim", {30'd0, victim}, 32'h0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    t_reset();
    t_write();
    t_hits();
    t_all_patterns();
    t_sequences();
    t_collisions();
    t_idle();
    step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1);
    t_rst_again();
    finish_run();
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule